// File: doc/BRIEF.md
# Power Partition Gate Controller

This block switches a set of power partitions on and off and controls the isolation clamps on their outputs. Software starts a power change by writing one command word. That word names a single partition and sets a start flag. The controller inverts that partition's power state through a request/acknowledge pair to the partition switch. The start flag stays set while the change is in flight and clears itself when the change is done. A status bitmap shows which partitions are powered. A second bitmap shows which partitions are still clamped.

Clamp removal is a separate, per-partition command bitmap. Each accepted bit reads back as 1 until the clamp has been released. Powering a partition down re-clamps it before its switch request drops. This order keeps a dying partition from driving undefined values into its neighbours. If a switch never acknowledges, a cycle-count timeout ends the operation, and the switch request returns to its previous level.

Access is through a plain 32-bit register bus. The bus carries a byte address, and the low two address bits are ignored.

Top module: `partition_power_gate`

## Requirements
- R1: After reset, every partition is unpowered and clamped: status reads 0, clamp status reads all partition bits as 1, the clamp command reads 0, the toggle register reads 0 and every switch request output is 0.
- R2: A write to byte offset 0x030 with bit 8 (start) set and bits 4:0 naming a partition below NPART is accepted when no operation is in flight. Bit 8 then reads 1 on the next read, and the partition's switch request moves to the inverted power state one cycle later.
- R3: When the partition's acknowledge input equals the requested state, the partition's bit in the status register (offset 0x038, bit n = partition n powered) takes the new state, and bit 8 of offset 0x030 clears in the same cycle.
- R4: If no matching acknowledge arrives within TIMEOUT_CYC cycles of the request, the start flag clears anyway, the switch request returns to its prior level and the status bit keeps its old value.
- R5: A toggle write that arrives while the start flag is set is dropped and is not queued. The in-flight partition index and the other partitions are unaffected.
- R6: A toggle write with bit 8 clear, or with an index of NPART or more, starts nothing.
- R7: On an accepted power-down, the partition's clamp status bit (offset 0x02C, bit n = partition n clamped) and its clamp output are set in the accepting cycle, one cycle before its switch request drops. An unrequested partition is never unclamped.
- R8: Writing 1 to bit n of offset 0x034 for a powered partition makes that bit read 1 for one cycle. The partition's clamp status bit then clears, and the command bit clears at the same time.
- R9: A clamp-removal bit for a partition that is unpowered, or that is the subject of an in-flight toggle, is ignored. Its command bit reads 0 and its clamp status bit stays 1.
- R10: The status and clamp status registers ignore writes. All bits at or above NPART read 0.
- R11: Offset 0x030 reads the start flag in bit 8 and the last accepted partition index in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| pwrReq | output | NPART | Per-partition switch request, 1 = power on |
| pwrAck | input | NPART | Per-partition switch acknowledge, the state the switch reports |
| clampOn | output | NPART | Per-partition isolation clamp enable |

## Verification
The bench builds the block with NPART = 8 and TIMEOUT_CYC = 20. With eight partitions, index values from 8 to 31 fall out of range, so the ignored-index path (R6) and the zero upper status bits (R10) can be checked. The 20-cycle timeout lets a switch model that never acknowledges drive the timeout path (R4) to completion in a few dozen cycles. This also measures the busy window against the timeout length. The switch model acknowledges one cycle after each request, which makes every normal toggle complete in a small, bounded number of polls.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Byte offsets of the registers; software and the read mux both decode these.
  localparam int OFF_CLAMP_STAT = 'h02C;
  localparam int OFF_TOGGLE     = 'h030;
  localparam int OFF_CLAMP_CMD  = 'h034;
  localparam int OFF_PWR_STAT   = 'h038;

  // Toggle word field positions.
  localparam int TGL_START_BIT = 8;
  localparam int TGL_IDX_W     = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } gateState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clampSet;    // re-clamp the partition named by the write
    logic reqDrive;    // drive switch request of active partition to target
    logic reqRestore;  // return switch request to previous level (timeout)
    logic commit;      // write target into power status
    logic target;      // requested power state of active partition
  } gateStrobe_t;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tglReq,
  input  logic [TGL_IDX_W-1:0] reqIdx,
  input  logic                 curOn,
  input  logic                 ackBit,
  output gateStrobe_t          strobe,
  output logic                 busy,
  output logic [TGL_IDX_W-1:0] idxReg
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYC - 1);

  gateState_e        state, stateNext;
  logic [CNT_W-1:0]  waitCnt;
  logic              targetReg;
  logic              acceptNow;
  logic              ackMatch;
  logic              timedOut;

  assign busy      = (state != ST_IDLE);
  assign acceptNow = (state == ST_IDLE) && tglReq;
  assign ackMatch  = (state == ST_WAIT) && (ackBit == targetReg);
  assign timedOut  = (state == ST_WAIT) && !ackMatch && (waitCnt == LAST_CNT);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (tglReq) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (ackMatch || timedOut) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.target     = targetReg;
    strobe.clampSet   = acceptNow && curOn;
    strobe.reqDrive   = (state == ST_ISSUE);
    strobe.commit     = ackMatch;
    strobe.reqRestore = timedOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      targetReg <= 1'b0;
      idxReg    <= '0;
    end else begin
      state <= stateNext;
      if (acceptNow) begin
        idxReg    <= reqIdx;
        targetReg <= !curOn;
      end
      if (state == ST_ISSUE)
        waitCnt <= '0;
      else if (state == ST_WAIT && !ackMatch && !timedOut)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  // R2: an accepted toggle always raises the busy flag on the next cycle.
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && tglReq) |=> busy);

  // R5: a toggle arriving mid-operation leaves the active index alone.
  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tglReq) |=> $stable(idxReg));

  // R4: the last wait cycle always ends the operation.
  assert_timeout_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && waitCnt == LAST_CNT) |=> !busy);

  // R3: completion only ever follows a wait cycle.
  assert_done_from_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(state) == ST_WAIT);

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int NPART  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NPART-1:0]     pwrAck,
  output logic [NPART-1:0]     pwrReq,
  output logic [NPART-1:0]     clampOn,
  input  gateStrobe_t          strobe,
  input  logic                 busy,
  input  logic [TGL_IDX_W-1:0] idxReg,
  output logic                 tglReq,
  output logic [TGL_IDX_W-1:0] reqIdx,
  output logic                 curOn,
  output logic                 ackBit
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CLAMP_STAT = WORD_W'(OFF_CLAMP_STAT >> 2);
  localparam logic [WORD_W-1:0] W_TOGGLE     = WORD_W'(OFF_TOGGLE >> 2);
  localparam logic [WORD_W-1:0] W_CLAMP_CMD  = WORD_W'(OFF_CLAMP_CMD >> 2);
  localparam logic [WORD_W-1:0] W_PWR_STAT   = WORD_W'(OFF_PWR_STAT >> 2);

  logic [WORD_W-1:0] wordSel;
  logic [NPART-1:0]  pwrStat;
  logic [NPART-1:0]  clampStat;
  logic [NPART-1:0]  clampCmd;
  logic [NPART-1:0]  reqMask;
  logic [NPART-1:0]  actMask;
  logic [NPART-1:0]  cmdAccept;
  logic [NPART-1:0]  reClamp;
  logic [31:0]       statPad, clampPad, cmdPad;
  logic              idxInRange;

  assign wordSel    = regAddr[ADDR_W-1:2];
  assign reqIdx     = regWrData[TGL_IDX_W-1:0];
  assign idxInRange = ({1'b0, reqIdx} < (TGL_IDX_W+1)'(NPART));
  assign tglReq     = regWrEn && (wordSel == W_TOGGLE) &&
                      regWrData[TGL_START_BIT] && idxInRange;
  assign reqMask    = NPART'(1) << reqIdx;
  assign actMask    = NPART'(1) << idxReg;
  assign curOn      = |(pwrStat & reqMask);
  assign ackBit     = |(pwrAck & actMask);
  assign reClamp    = strobe.clampSet ? reqMask : '0;

  // Clamp removal only for powered partitions not under a toggle.
  always_comb begin
    cmdAccept = '0;
    if (regWrEn && wordSel == W_CLAMP_CMD)
      cmdAccept = regWrData[NPART-1:0] & pwrStat & ~reClamp &
                  ~(busy ? actMask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrStat   <= '0;
      pwrReq    <= '0;
      clampStat <= '1;
      clampCmd  <= '0;
    end else begin
      if (strobe.commit)
        pwrStat <= strobe.target ? (pwrStat | actMask) : (pwrStat & ~actMask);
      if (strobe.reqDrive)
        pwrReq <= strobe.target ? (pwrReq | actMask) : (pwrReq & ~actMask);
      else if (strobe.reqRestore)
        pwrReq <= strobe.target ? (pwrReq & ~actMask) : (pwrReq | actMask);
      clampStat <= (clampStat & ~clampCmd) | reClamp;
      clampCmd  <= cmdAccept;
    end
  end

  assign clampOn = clampStat;

  always_comb begin
    statPad  = '0;
    clampPad = '0;
    cmdPad   = '0;
    statPad[NPART-1:0]  = pwrStat;
    clampPad[NPART-1:0] = clampStat;
    cmdPad[NPART-1:0]   = clampCmd;
  end

  always_comb begin
    regRdData = '0;
    unique case (wordSel)
      W_CLAMP_STAT: regRdData = clampPad;
      W_TOGGLE: begin
        regRdData[TGL_START_BIT]     = busy;
        regRdData[TGL_IDX_W-1:0]     = idxReg;
      end
      W_CLAMP_CMD:  regRdData = cmdPad;
      W_PWR_STAT:   regRdData = statPad;
      default:      regRdData = '0;
    endcase
  end

  // R7: a partition whose switch request is low is always clamped.
  assert_unreq_clamped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (~pwrReq & ~clampStat) == '0);

  // R9: pending clamp removals only target powered partitions.
  assert_cmd_powered_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clampCmd & ~pwrStat) == '0);

  // R8: a pending removal has released its clamp one cycle later unless re-clamped.
  assert_cmd_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|clampCmd) |=> (((clampStat & $past(clampCmd)) == '0) || busy));

  // R1: unpowered partitions never lose their clamp.
  assert_off_clamped_R1: assert property (@(posedge clk) disable iff (!rstN)
    (~pwrStat & ~clampStat) == '0);

endmodule

// File: rtl/partition_power_gate.sv
module partition_power_gate
  import ppg_pkg::*;
#(
  parameter int NPART       = 32,
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [NPART-1:0]  pwrReq,
  input  logic [NPART-1:0]  pwrAck,
  output logic [NPART-1:0]  clampOn
);

  gateStrobe_t          strobe;
  logic                 busy;
  logic [TGL_IDX_W-1:0] idxReg;
  logic                 tglReq;
  logic [TGL_IDX_W-1:0] reqIdx;
  logic                 curOn;
  logic                 ackBit;

  ppg_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tglReq (tglReq),
    .reqIdx (reqIdx),
    .curOn  (curOn),
    .ackBit (ackBit),
    .strobe (strobe),
    .busy   (busy),
    .idxReg (idxReg)
  );

  ppg_datapath #(.NPART(NPART), .ADDR_W(ADDR_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pwrAck    (pwrAck),
    .pwrReq    (pwrReq),
    .clampOn   (clampOn),
    .strobe    (strobe),
    .busy      (busy),
    .idxReg    (idxReg),
    .tglReq    (tglReq),
    .reqIdx    (reqIdx),
    .curOn     (curOn),
    .ackBit    (ackBit)
  );

endmodule

// File: tb/partition_power_gate_test.sv
`timescale 1ns/1ps
module partition_power_gate_test;

  localparam int NPART  = 8;
  localparam int ADDR_W = 12;
  localparam int TOUT   = 20;

  localparam logic [ADDR_W-1:0] A_CLAMP = 12'h02C;
  localparam logic [ADDR_W-1:0] A_TGL   = 12'h030;
  localparam logic [ADDR_W-1:0] A_CMD   = 12'h034;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h038;

  // Toggle sequence: [12:8] partition, [7:0] expected status after completion.
  localparam int NVEC = 5;
  localparam logic [12:0] VEC [NVEC] = '{
    {5'd3, 8'h08}, {5'd5, 8'h28}, {5'd3, 8'h20}, {5'd7, 8'hA0}, {5'd0, 8'hA1}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWrEn;
  logic [ADDR_W-1:0] regAddr;
  logic [31:0]       regWrData;
  logic [31:0]       regRdData;
  logic [NPART-1:0]  pwrReq;
  logic [NPART-1:0]  pwrAck;
  logic [NPART-1:0]  clampOn;
  logic [NPART-1:0]  deadMask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  partition_power_gate #(.NPART(NPART), .ADDR_W(ADDR_W), .TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwrReq(pwrReq),
    .pwrAck(pwrAck), .clampOn(clampOn)
  );

  // Switch model: follows the request one cycle later unless dead.
  always_ff @(posedge clk) begin
    if (!rstN) pwrAck <= '0;
    else       pwrAck <= pwrReq & ~deadMask;
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle(input int limit, output int n);
    logic [31:0] v;
    n = 0;
    rd(A_TGL, v);
    while (v[8] && n < limit) begin
      @(negedge clk);
      n++;
      rd(A_TGL, v);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; deadMask = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);  checkEq("R1 status", v, 32'h0);
    rd(A_CLAMP, v); checkEq("R1 clamp status", v, 32'h0000_00FF);
    rd(A_CMD, v);   checkEq("R1 clamp cmd", v, 32'h0);
    rd(A_TGL, v);   checkEq("R1 toggle", v, 32'h0);
    checkEq("R1 pwrReq", 32'(pwrReq), 32'h0);
    checkEq("R1 clampOn", 32'(clampOn), 32'hFF);

    // R2, R3, R11 vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] idx;
      logic [7:0] exp;
      idx = VEC[i][12:8];
      exp = VEC[i][7:0];
      wr(A_TGL, 32'h100 | 32'(idx));
      rd(A_TGL, v);
      checkEq("R2 R11 start and index", v, 32'h100 | 32'(idx));
      @(negedge clk);
      checkEq("R2 request inverted", 32'(pwrReq[idx]), 32'(exp[idx]));
      waitIdle(10, n);
      checkEq("R3 completes on ack", 32'(n < 10), 32'h1);
      rd(A_STAT, v);
      checkEq("R3 status", v, 32'(exp));
    end
    rd(A_CLAMP, v); checkEq("R8 clamps held until removal", v, 32'hFF);

    // R8 clamp removal of a powered partition
    wr(A_CMD, 32'h20);
    rd(A_CMD, v); checkEq("R8 cmd pending", v, 32'h20);
    @(negedge clk);
    rd(A_CMD, v);   checkEq("R8 cmd cleared", v, 32'h0);
    rd(A_CLAMP, v); checkEq("R8 clamp released", v, 32'hDF);
    checkEq("R8 clampOn", 32'(clampOn), 32'hDF);

    // R9 removal for unpowered partitions ignored, mixed with powered ones
    wr(A_CMD, 32'h06);
    rd(A_CMD, v); checkEq("R9 cmd ignored", v, 32'h0);
    @(negedge clk);
    rd(A_CLAMP, v); checkEq("R9 clamps kept", v, 32'hDF);
    wr(A_CMD, 32'h83);
    rd(A_CMD, v); checkEq("R9 only powered accepted", v, 32'h81);
    @(negedge clk);
    rd(A_CLAMP, v); checkEq("R9 mixed clamp", v, 32'h5E);

    // R7 power-down re-clamps before request drops
    wr(A_TGL, 32'h105);
    checkEq("R7 clamp set at accept", 32'(clampOn), 32'h7E);
    checkEq("R7 request still high", 32'(pwrReq), 32'hA1);
    @(negedge clk);
    checkEq("R7 request dropped", 32'(pwrReq), 32'h81);
    waitIdle(10, n);
    rd(A_STAT, v); checkEq("R7 status off", v, 32'h81);

    // R5 toggle while busy dropped
    wr(A_TGL, 32'h101);
    wr(A_TGL, 32'h102);
    rd(A_TGL, v); checkEq("R5 index kept", v, 32'h101);
    waitIdle(10, n);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); checkEq("R5 second toggle not queued", v, 32'h83);
    rd(A_TGL, v);  checkEq("R11 index retained", v, 32'h001);

    // R6 out-of-range index and missing start flag
    wr(A_TGL, 32'h109);
    rd(A_TGL, v); checkEq("R6 out of range ignored", v, 32'h001);
    wr(A_TGL, 32'h004);
    rd(A_TGL, v); checkEq("R6 no start ignored", v, 32'h001);
    repeat (3) @(negedge clk);
    checkEq("R6 requests unchanged", 32'(pwrReq), 32'h83);

    // R4 timeout with a dead switch
    deadMask = 8'h10;
    wr(A_TGL, 32'h104);
    @(negedge clk);
    checkEq("R4 request raised", 32'(pwrReq), 32'h93);
    waitIdle(60, n);
    checkEq("R4 busy spans timeout", 32'((n >= TOUT - 3) && (n <= TOUT + 3)), 32'h1);
    rd(A_STAT, v); checkEq("R4 status unchanged", v, 32'h83);
    checkEq("R4 request restored", 32'(pwrReq), 32'h83);
    checkEq("R4 clamp kept", 32'(clampOn[4]), 32'h1);
    deadMask = '0;

    // R10 read-only registers
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_CLAMP, 32'h0);
    rd(A_STAT, v);  checkEq("R10 status read-only", v, 32'h83);
    rd(A_CLAMP, v); checkEq("R10 clamp read-only", v, 32'h7E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule